// File: doc/BRIEF.md
# Watchdog External Reset Pulse Generator

This block produces the external reset pulse that a watchdog raises after its counter times out. A single 32-bit configuration register holds three things: a pulse-length field in its low bits, a polarity bit and a drive-style bit. Software writes the register with one data word. The low field is always taken from that word. The polarity and drive bits change only when the top byte of the word carries one of four key values. Any other top byte leaves both bits as they were.

When the trigger input is sampled high while no pulse is running, the block drives its pin to the active level for (length + 1) ticks of a 1 MHz time base. The tick is made from the block clock by a divider parameter. The block outputs the pin value together with an output-enable, so that the pad logic can model either a push-pull or an open-drain driver.

Top module: `wdt_ext_pulse`

## Requirements
- R1: After reset the register reads 0x000000FF: active-low polarity (bit 31 = 0), open-drain drive (bit 30 = 0) and length 0xFF. The pin is then at its idle level (pin_o = 1) and the output-enable is 0.
- R2: A write whose bits 31:24 equal 0xA5 sets the polarity to active high, and bit 31 then reads 1. A write with 0x5A in those bits sets active low, and bit 31 then reads 0.
- R3: A write whose bits 31:24 equal 0xA8 selects push-pull, and bit 30 then reads 1. A write with 0x8A in those bits selects open-drain, and bit 30 then reads 0.
- R4: A write with any other value in bits 31:24 leaves bits 31 and 30 unchanged.
- R5: Every write loads bits DUR_W-1:0 of the data into the length field, whatever the top byte holds. Bits 29:DUR_W read as zero. DUR_W is 20 by default and 8 in the narrow variant.
- R6: A trigger that is sampled high at a clock edge with no pulse running starts a pulse after that edge. The pulse lasts (length + 1) × TICK_DIV clock cycles.
- R7: During a pulse, pin_o equals the active level (1 for active high, 0 for active low). At all other times pin_o is the opposite level.
- R8: In push-pull mode pin_oe is always 1. In open-drain mode pin_oe is 1 only while a pulse is running.
- R9: A trigger that arrives while a pulse is running, including in the pulse's final cycle, has no effect. The pulse neither lengthens nor restarts.
- R10: The length is captured when the pulse starts. A register write during a pulse does not change the length of that pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read value |
| trig | input | 1 | Timeout trigger |
| pin_o | output | 1 | Pin level |
| pin_oe | output | 1 | Pin output-enable |

## Verification
The bench goes after the key decode. A design that let a non-key top byte touch the mode bits would flip polarity or drive when software only meant to change the length. It checks pulse length at small lengths and checks the off-by-one: a design that counted N instead of N+1 ticks would give a pulse one tick short. It also re-triggers in the middle of a pulse and in its last cycle, and rewrites the length during a pulse. A faulty design would then stretch, restart or resize the running pulse. Open-drain enable timing is compared on every cycle, so an enable that stays on while idle is caught at once.

// File: rtl/wdt_ext_pulse.sv
module wdt_ext_pulse #(
  parameter int DUR_W    = 20,
  parameter int TICK_DIV = 100,
  parameter logic [DUR_W-1:0] DUR_RST = DUR_W'(8'hFF)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        trig,
  output logic        pin_o,
  output logic        pin_oe
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [7:0] KEY_HIGH = 8'hA5;
  localparam logic [7:0] KEY_LOW  = 8'h5A;
  localparam logic [7:0] KEY_PP   = 8'hA8;
  localparam logic [7:0] KEY_OD   = 8'h8A;

  logic             act_high, push_pull, active;
  logic [DUR_W-1:0] dur, remain;
  logic [PW-1:0]    pre;
  logic             tick_end;
  logic [7:0]       key;

  assign key      = wr_data[31:24];
  assign tick_end = (pre == PW'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_high  <= 1'b0;
      push_pull <= 1'b0;
      dur       <= DUR_RST;
    end else if (wr_en) begin
      dur <= wr_data[DUR_W-1:0];
      case (key)
        KEY_HIGH: act_high  <= 1'b1;
        KEY_LOW:  act_high  <= 1'b0;
        KEY_PP:   push_pull <= 1'b1;
        KEY_OD:   push_pull <= 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      remain <= '0;
      pre    <= '0;
    end else if (!active) begin
      if (trig) begin
        active <= 1'b1;
        remain <= dur;
        pre    <= '0;
      end
    end else if (tick_end) begin
      pre <= '0;
      if (remain == '0) active <= 1'b0;
      else              remain <= remain - 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  assign rd_data = {act_high, push_pull, 30'(dur)};
  assign pin_o   = act_high ? active : ~active;
  assign pin_oe  = push_pull | active;

  p_key_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && key == KEY_HIGH) |=> rd_data[31]);
  p_key_pp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && key == KEY_PP) |=> rd_data[30]);
  p_nokey_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && key != KEY_HIGH && key != KEY_LOW && key != KEY_PP && key != KEY_OD)
      |=> $stable(rd_data[31:30]));
  p_dur_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> dur == $past(wr_data[DUR_W-1:0]));
  p_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && trig) |=> (active && remain == $past(dur) && pre == '0));
  p_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && tick_end && remain == '0) |=> !active);
  p_od_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[30] && !active) |-> !pin_oe);
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && trig && !tick_end) |=> (active && $stable(remain)));
endmodule

// File: tb/wdt_ext_pulse_bench.sv
module wdt_ext_pulse_bench;
  localparam int DW  = 20;
  localparam int DIV = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        trig = 1'b0;
  logic [31:0] rd_data;
  logic        pin_o, pin_oe;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wdt_ext_pulse #(.DUR_W(DW), .TICK_DIV(DIV)) u_wdt_ext_pulse (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .trig(trig), .pin_o(pin_o), .pin_oe(pin_oe));

  bit m_hi = 0, m_pp = 0;
  int m_dur = 255, m_left = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hi = 0; m_pp = 0; m_dur = 255; m_left = 0;
    end else begin
      if (m_left > 0) m_left--;
      else if (trig) m_left = (m_dur + 1) * DIV;
      if (wr_en) begin
        m_dur = int'(wr_data[DW-1:0]);
        case (wr_data[31:24])
          8'hA5: m_hi = 1;
          8'h5A: m_hi = 0;
          8'hA8: m_pp = 1;
          8'h8A: m_pp = 0;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic act;
      logic [31:0] exp_rd;
      act = (m_left > 0);
      exp_rd = {m_hi, m_pp, 30'(m_dur)};
      chk(rd_data == exp_rd, "R2/R3/R4/R5 model rd", rd_data, exp_rd);
      chk(pin_o == (m_hi ? act : !act), "R6/R7 model pin", {31'd0, pin_o}, {31'd0, (m_hi ? act : !act)});
      chk(pin_oe == (m_pp | act), "R8 model oe", {31'd0, pin_oe}, {31'd0, (m_pp | act)});
    end
  end

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(input bit lvl, input int retrig_at, input int rewrite_at,
                       input logic [31:0] rw, output int len);
    len = 0;
    @(negedge clk); trig = 1'b1;
    for (int i = 0; i < 10000; i++) begin
      @(negedge clk);
      trig = 1'b0; wr_en = 1'b0;
      if (pin_o != lvl) break;
      len++;
      if (i == retrig_at) trig = 1'b1;
      if (i == rewrite_at) begin wr_en = 1'b1; wr_data = rw; end
    end
    trig = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int len;
    repeat (3) @(negedge clk);
    chk(rd_data == 32'h000000FF, "R1 reset rd", rd_data, 32'h000000FF);
    chk(pin_o == 1'b1, "R1 reset pin", {31'd0, pin_o}, 32'd1);
    chk(pin_oe == 1'b0, "R1 reset oe", {31'd0, pin_oe}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    wr(32'hA5000010);
    chk(rd_data == 32'h80000010, "R2 key high", rd_data, 32'h80000010);
    wr(32'h5A000011);
    chk(rd_data == 32'h00000011, "R2 key low", rd_data, 32'h00000011);
    wr(32'hA8000003);
    chk(rd_data == 32'h40000003, "R3 key push-pull", rd_data, 32'h40000003);
    wr(32'h12000007);
    chk(rd_data == 32'h40000007, "R4 other key keeps mode", rd_data, 32'h40000007);
    wr(32'hA4FFFFFF);
    chk(rd_data == 32'h400FFFFF, "R4 R5 near-key and high bits", rd_data, 32'h400FFFFF);
    wr(32'h8A000004);
    chk(rd_data == 32'h00000004, "R3 key open-drain", rd_data, 32'h00000004);

    pulse(1'b0, -1, -1, 0, len);
    chk(len == 5 * DIV, "R6 R7 active-low length", len, 5 * DIV);
    chk(pin_oe == 1'b0, "R8 od released after pulse", {31'd0, pin_oe}, 32'd0);

    wr(32'hA5000002); wr(32'hA8000002);
    pulse(1'b1, -1, -1, 0, len);
    chk(len == 3 * DIV, "R6 R7 active-high length", len, 3 * DIV);
    chk(pin_oe == 1'b1 && pin_o == 1'b0, "R8 push-pull idle drive", {30'd0, pin_oe, pin_o}, 32'd2);

    pulse(1'b1, 4, -1, 0, len);
    chk(len == 3 * DIV, "R9 mid-pulse retrigger", len, 3 * DIV);
    pulse(1'b1, 3 * DIV - 1, -1, 0, len);
    chk(len == 3 * DIV, "R9 last-cycle retrigger", len, 3 * DIV);
    @(negedge clk);
    chk(pin_o == 1'b0, "R9 no restart after end", {31'd0, pin_o}, 32'd0);

    wr(32'h00000005);
    pulse(1'b1, -1, 2, 32'h00000001, len);
    chk(len == 6 * DIV, "R10 write during pulse", len, 6 * DIV);
    pulse(1'b1, -1, -1, 0, len);
    chk(len == 2 * DIV, "R10 new length next pulse", len, 2 * DIV);

    wr(32'h5A000000); wr(32'h8A000000);
    pulse(1'b0, -1, -1, 0, len);
    chk(len == DIV, "R6 zero length gives one tick", len, DIV);

    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      wr_en = (k % 7 == 3);
      wr_data = {(k % 4 == 0) ? 8'hA5 : (k % 4 == 1) ? 8'hA8 : (k % 4 == 2) ? 8'h5A : 8'h33, 24'(k % 6)};
      trig = (k % 5 == 0);
    end
    @(negedge clk); wr_en = 1'b0; trig = 1'b0;
    repeat (40) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule